// File: doc/BRIEF.md
# Dual/Quad SPI Flash Command Sequencer

This block runs one complete flash command frame on a serial flash bus that has four data lanes. A frame has four phases: an 8-bit instruction sent on a single lane, an address of 24 or 32 bits, a programmable run of dummy clocks, and a data phase. The address and data phases use two lanes in dual format and four lanes in quad format. A frame either only receives (a read) or only transmits (a write). Software loads a 32-bit transmit queue in order: the instruction word, then the address word, then one word per data byte for a write. Received bytes collect in a byte-wide receive queue.

The frame settings are sampled once, in the cycle that `start` is accepted. These are the lane format, the address-size code, the dummy-clock count, the direction and the data count minus one. The serial clock runs at half the system clock rate, or slower. It never produces a rising edge that would corrupt the frame. A read holds the clock low while the receive queue is full. A write holds it low while the transmit queue has no byte ready. Long transfers therefore pace themselves to software without overflow or underrun.

Top module: `qspi_cmd_seq`

## Requirements
- R1: The first clocks of a frame are 8 instruction clocks. Only lane 0 is enabled (`spi_io_oe` = 4'b0001). Lane 0 carries bits [7:0] of the first queued word, most significant bit first.
- R2: The address comes from the second queued word and is sent on the frame's lanes, most significant bits first. Address code 6 gives 24 bits (word bits [23:0]). Any other code gives 32 bits. Lane format 1 (dual) uses lanes 1:0, with lane 1 carrying the higher bit. Format 2 (quad) uses lanes 3:0, with lane 3 highest.
- R3: After the address come exactly `wait_cycles` clocks with every lane enable low. A count of 0 gives no dummy clocks.
- R4: A write sends `frames_m1`+1 bytes, each taken from bits [7:0] of the next queued word. Each byte is sent high bits first and takes 4 clocks in dual format or 2 clocks in quad format. The frame's lanes are enabled during this phase.
- R5: A read keeps every lane enable low during the data phase. It samples the lanes on each rising clock edge and assembles each byte high bits first. It pushes `frames_m1`+1 bytes into the receive queue, in order.
- R6: During a read, the serial clock stays low while the receive queue is full. A byte is never pushed into a full queue. The frame continues once software pops.
- R7: During a frame, the serial clock stays low while a needed transmit word is missing. The frame continues once the word is queued, and no queue entry is read while the queue is empty.
- R8: A frame lasts 8 + address_bits/lanes + wait_cycles + bytes*8/lanes clocks. After the last falling edge, `spi_cs_n` returns high and `busy` falls. While idle, `spi_cs_n` is high and `spi_sclk` is low.
- R9: `start` has no effect while `busy` is high, or when the lane format is 0 or 3. Settings presented with an ignored `start` do not change the frame in progress.
- R10: After reset, `busy` = 0, `spi_cs_n` = 1, `spi_sclk` = 0, `spi_io_oe` = 0 and `rx_empty` = 1.
- R11: `spi_io_out` and `spi_io_oe` change only while the serial clock is low. They hold steady in every cycle that `spi_sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame with the presented settings |
| lane_fmt | input | 2 | 1 = dual, 2 = quad; other codes refuse the frame |
| addr_code | input | 4 | Address size in 4-bit units; 6 = 24 bits, else 32 bits |
| wait_cycles | input | 5 | Dummy clocks between address and data |
| write_mode | input | 1 | 1 = transmit-only frame, 0 = receive-only frame |
| frames_m1 | input | CNT_W | Data byte count minus one |
| tx_push | input | 1 | Write one word into the transmit queue |
| tx_wdata | input | 32 | Word to queue |
| tx_full | output | 1 | Transmit queue is full |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_rdata | output | 8 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue is empty |
| busy | output | 1 | A frame is in progress |
| spi_cs_n | output | 1 | Active-low flash select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_io_out | output | 4 | Lane output values |
| spi_io_oe | output | 4 | Lane output enables |
| spi_io_in | input | 4 | Lane input values |

## Verification
The bench builds the block with a 4-entry transmit queue and a 4-entry receive queue. Both queues then fill within a few bytes, so the clock stall on a full receive queue and the stall on a missing transmit word occur in short frames. The bench freezes the clock at a computed edge count in each case. With a 16-bit count and 32-bit words kept at their defaults, the bench sweeps both lane formats, both address sizes, both directions, zero and non-zero dummy counts, and one- and three-byte frames. It also runs the 31-clock dummy maximum, a 12-byte read, and refused and mid-frame starts. Every lane value on every rising edge is compared with a stream the bench computes on its own.

// File: rtl/qcs_pkg.sv
package qcs_pkg;
  localparam int WORD_W = 32;
  localparam logic [1:0] FMT_DUAL = 2'd1;
  localparam logic [1:0] FMT_QUAD = 2'd2;
  localparam logic [3:0] ADDR_CODE_24 = 4'd6;

  typedef enum logic [2:0] {
    PH_INS,
    PH_ADR,
    PH_DUMMY,
    PH_DATA,
    PH_DONE
  } qcs_phase_e;

  // enable pattern for a lane count of 1, 2 or 4
  function automatic logic [3:0] lane_mask(input logic [2:0] lanes);
    case (lanes)
      3'd4:    return 4'b1111;
      3'd2:    return 4'b0011;
      default: return 4'b0001;
    endcase
  endfunction

  // serial clocks needed for the address phase
  function automatic logic [5:0] addr_clocks(input logic wide_addr, input logic [2:0] lanes);
    if (wide_addr) return (lanes == 3'd4) ? 6'd8 : 6'd16;
    return (lanes == 3'd4) ? 6'd6 : 6'd12;
  endfunction

  // serial clocks per data byte
  function automatic logic [5:0] byte_clocks(input logic [2:0] lanes);
    return (lanes == 3'd4) ? 6'd2 : 6'd4;
  endfunction
endpackage

// File: rtl/qcs_fifo.sv
module qcs_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] LEVEL_FULL = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp, wp_nx, rp_nx;
  logic [AW:0]      level;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  generate
    if (DEPTH == (1 << AW)) begin : g_pow2
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
    end else begin : g_wrap
      assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= wp_nx;
      if (do_pop)  rp <= rp_nx;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rdata = mem[rp];
  assign full  = (level == LEVEL_FULL);
  assign empty = (level == '0);
endmodule

// File: rtl/qcs_engine.sv
module qcs_engine
  import qcs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        fmt,
  input  logic [3:0]        alen_code,
  input  logic [4:0]        wait_n,
  input  logic              dir_wr,
  input  logic [CNT_W-1:0]  count_m1,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [7:0]        rx_byte,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);
  qcs_phase_e        ph;
  logic              ready;
  logic [5:0]        units;
  logic [WORD_W-1:0] sh;
  logic [7:0]        rxsh, rx_next;
  logic [2:0]        cur, wide;
  logic              a32, wr_q;
  logic [4:0]        wait_q;
  logic [CNT_W-1:0]  left;
  logic [3:0]        drive;
  logic              fmt_ok, loading, rd_data, rx_hold;

  assign fmt_ok  = (fmt == FMT_DUAL) || (fmt == FMT_QUAD);
  assign loading = busy && !sclk && !ready;
  assign rd_data = (ph == PH_DATA) && !wr_q;
  assign rx_hold = rd_data && rx_full;
  assign tx_pop  = loading && !tx_empty &&
                   ((ph == PH_INS) || (ph == PH_ADR) || ((ph == PH_DATA) && wr_q));

  always_comb begin
    case (cur)
      3'd4:    drive = sh[WORD_W-1 -: 4];
      3'd2:    drive = {2'b00, sh[WORD_W-1 -: 2]};
      default: drive = {3'b000, sh[WORD_W-1]};
    endcase
  end

  assign rx_next = (cur == 3'd4) ? {rxsh[3:0], io_in} : {rxsh[5:0], io_in[1:0]};
  assign io_out  = drive & io_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      ready   <= 1'b0;
      ph      <= PH_INS;
      units   <= '0;
      sh      <= '0;
      rxsh    <= '0;
      cur     <= 3'd1;
      wide    <= 3'd4;
      a32     <= 1'b1;
      wr_q    <= 1'b0;
      wait_q  <= '0;
      left    <= '0;
      io_oe   <= '0;
      rx_push <= 1'b0;
      rx_byte <= '0;
    end else begin
      rx_push <= 1'b0;
      if (!busy) begin
        if (start && fmt_ok) begin
          busy   <= 1'b1;
          cs_n   <= 1'b0;
          ph     <= PH_INS;
          ready  <= 1'b0;
          wide   <= (fmt == FMT_QUAD) ? 3'd4 : 3'd2;
          a32    <= (alen_code != ADDR_CODE_24);
          wait_q <= wait_n;
          wr_q   <= dir_wr;
          left   <= count_m1;
        end
      end else if (sclk) begin
        // falling edge: advance the shifter or close the unit
        sclk <= 1'b0;
        if (units == 6'd1) begin
          ready <= 1'b0;
          case (ph)
            PH_INS:   ph <= PH_ADR;
            PH_ADR:   ph <= PH_DUMMY;
            PH_DUMMY: ph <= PH_DATA;
            PH_DATA: begin
              if (!wr_q) begin
                rx_push <= 1'b1;
                rx_byte <= rxsh;
              end
              if (left == '0) ph <= PH_DONE;
              else left <= left - 1'b1;
            end
            default: ph <= PH_DONE;
          endcase
        end else begin
          units <= units - 1'b1;
          sh    <= sh << cur;
        end
      end else if (ready) begin
        // rising edge unless the receive queue cannot take the byte
        if (!rx_hold) begin
          sclk <= 1'b1;
          if (rd_data) rxsh <= rx_next;
        end
      end else begin
        // load the next unit once its source is available
        case (ph)
          PH_INS: if (!tx_empty) begin
            sh    <= {tx_word[7:0], 24'h0};
            cur   <= 3'd1;
            units <= 6'd8;
            io_oe <= 4'b0001;
            ready <= 1'b1;
          end
          PH_ADR: if (!tx_empty) begin
            sh    <= a32 ? tx_word : {tx_word[23:0], 8'h0};
            cur   <= wide;
            units <= addr_clocks(a32, wide);
            io_oe <= lane_mask(wide);
            ready <= 1'b1;
          end
          PH_DUMMY: begin
            if (wait_q == '0) begin
              ph <= PH_DATA;
            end else begin
              units <= {1'b0, wait_q};
              io_oe <= '0;
              ready <= 1'b1;
            end
          end
          PH_DATA: begin
            if (wr_q) begin
              if (!tx_empty) begin
                sh    <= {tx_word[7:0], 24'h0};
                cur   <= wide;
                units <= byte_clocks(wide);
                io_oe <= lane_mask(wide);
                ready <= 1'b1;
              end
            end else begin
              cur   <= wide;
              units <= byte_clocks(wide);
              io_oe <= '0;
              ready <= 1'b1;
            end
          end
          default: begin
            busy  <= 1'b0;
            cs_n  <= 1'b1;
            io_oe <= '0;
            ph    <= PH_INS;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/qspi_cmd_seq.sv
module qspi_cmd_seq
  import qcs_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       lane_fmt,
  input  logic [3:0]       addr_code,
  input  logic [4:0]       wait_cycles,
  input  logic             write_mode,
  input  logic [CNT_W-1:0] frames_m1,
  input  logic             tx_push,
  input  logic [31:0]      tx_wdata,
  output logic             tx_full,
  input  logic             rx_pop,
  output logic [7:0]       rx_rdata,
  output logic             rx_empty,
  output logic             busy,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic [3:0]       spi_io_out,
  output logic [3:0]       spi_io_oe,
  input  logic [3:0]       spi_io_in
);
  logic [WORD_W-1:0] tx_head_w;
  logic              tx_pop_w, tx_empty_w;
  logic              rx_push_w, rx_full_w;
  logic [7:0]        rx_byte_w;

  qcs_fifo #(.WIDTH(WORD_W), .DEPTH(TX_DEPTH)) i_txq (
    .clk(clk), .rst(rst),
    .push(tx_push), .wdata(tx_wdata),
    .pop(tx_pop_w), .rdata(tx_head_w),
    .full(tx_full), .empty(tx_empty_w)
  );

  qcs_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) i_rxq (
    .clk(clk), .rst(rst),
    .push(rx_push_w), .wdata(rx_byte_w),
    .pop(rx_pop), .rdata(rx_rdata),
    .full(rx_full_w), .empty(rx_empty)
  );

  qcs_engine #(.CNT_W(CNT_W)) i_engine (
    .clk(clk), .rst(rst),
    .start(start), .fmt(lane_fmt), .alen_code(addr_code),
    .wait_n(wait_cycles), .dir_wr(write_mode), .count_m1(frames_m1),
    .tx_empty(tx_empty_w), .tx_word(tx_head_w), .tx_pop(tx_pop_w),
    .rx_full(rx_full_w), .rx_push(rx_push_w), .rx_byte(rx_byte_w),
    .busy(busy), .cs_n(spi_cs_n), .sclk(spi_sclk),
    .io_out(spi_io_out), .io_oe(spi_io_oe), .io_in(spi_io_in)
  );
endmodule

// File: rtl/qcs_checker.sv
module qcs_checker (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_out,
  input logic [3:0] io_oe,
  input logic       rx_push,
  input logic       rx_full,
  input logic       tx_pop,
  input logic       tx_empty
);
  assert_rx_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !rx_full);

  assert_tx_no_underrun_R7: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> !tx_empty);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sclk));

  assert_clock_needs_select_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  assert_lanes_hold_high_R11: assert property (@(posedge clk) disable iff (rst)
    sclk |-> ($stable(io_out) && $stable(io_oe)));
endmodule

bind qspi_cmd_seq qcs_checker i_qcs_checker (
  .clk(clk), .rst(rst), .busy(busy), .cs_n(spi_cs_n), .sclk(spi_sclk),
  .io_out(spi_io_out), .io_oe(spi_io_oe),
  .rx_push(rx_push_w), .rx_full(rx_full_w),
  .tx_pop(tx_pop_w), .tx_empty(tx_empty_w)
);

// File: tb/test_qspi_cmd_seq.sv
module test_qspi_cmd_seq;
  localparam int TXD = 4;
  localparam int RXD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  lane_fmt = 2'd1;
  logic [3:0]  addr_code = 4'd6;
  logic [4:0]  wait_cycles = '0;
  logic        write_mode = 1'b0;
  logic [15:0] frames_m1 = '0;
  logic        tx_push = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic        tx_full;
  logic        rx_pop = 1'b0;
  logic [7:0]  rx_rdata;
  logic        rx_empty;
  logic        busy, spi_cs_n, spi_sclk;
  logic [3:0]  spi_io_out, spi_io_oe, spi_io_in;

  always #2.5 clk = ~clk;

  qspi_cmd_seq #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .CNT_W(16)) i_qspi_cmd_seq (
    .clk(clk), .rst(rst), .start(start), .lane_fmt(lane_fmt), .addr_code(addr_code),
    .wait_cycles(wait_cycles), .write_mode(write_mode), .frames_m1(frames_m1),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_empty(rx_empty),
    .busy(busy), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit wd_hit = 1'b0;

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int b, input int seed);
    return 8'(b * 53 + seed * 29 + 29);
  endfunction

  // flash model: lane values for clock index fn of the current frame
  function automatic logic [3:0] dev_val(input int fn, input int lanes, input int d0, input int seed);
    int per, j, b, p;
    logic [7:0] v;
    if (fn < d0) return 4'h5;
    per = 8 / lanes;
    j = fn - d0;
    b = j / per;
    p = j % per;
    v = byte_of(b, seed);
    return 4'((int'(v) >> (8 - lanes * (p + 1))) & ((1 << lanes) - 1));
  endfunction

  int cL = 2, cD0 = 1000, cSeed = 0;
  int rise_n = 0, fall_n = 0;
  logic [3:0] cap_io [1024];
  logic [3:0] cap_oe [1024];
  logic pc = 1'b1, ps = 1'b0;

  assign spi_io_in = dev_val(fall_n, cL, cD0, cSeed);

  always @(negedge clk) begin
    cyc++;
    if (pc && !spi_cs_n) begin
      rise_n = 0;
      fall_n = 0;
    end
    if (!ps && spi_sclk) begin
      if (rise_n < 1024) begin
        cap_io[rise_n] = spi_io_out;
        cap_oe[rise_n] = spi_io_oe;
      end
      rise_n++;
    end
    if (ps && !spi_sclk) fall_n++;
    pc = spi_cs_n;
    ps = spi_sclk;
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // mode 0 plain, 1 read with held pops (R6), 2 write with held words (R7), 3 start during frame (R9)
  task automatic run_frame(input int fmt, input bit a32, input int w, input bit wr,
                           input int n, input int seed, input int mode);
    int lanes, ac, per, d0, total, tx_total, tx_i, rx_i, lim, t, bad_rd, stall_exp;
    int bad [1:4];
    logic [31:0] insw, adw;
    logic [3:0] m, eo, ei;
    lanes = (fmt == 2) ? 4 : 2;
    ac = (a32 ? 32 : 24) / lanes;
    per = 8 / lanes;
    d0 = 8 + ac + w;
    total = d0 + n * per;
    tx_total = wr ? 2 + n : 2;
    tx_i = 0; rx_i = 0; t = 0; bad_rd = 0;
    bad[1] = 0; bad[2] = 0; bad[3] = 0; bad[4] = 0;
    insw = {8'hE7, 8'(seed), 8'h3C, 8'(11 + seed * 7)};
    adw = 32'h8A4C2E61 ^ (32'(seed) * 32'h01010305);
    m = (lanes == 4) ? 4'hF : 4'h3;
    cL = lanes; cD0 = d0; cSeed = seed;
    @(negedge clk);
    lane_fmt = 2'(fmt);
    addr_code = a32 ? 4'd8 : 4'd6;
    wait_cycles = 5'(w);
    write_mode = wr;
    frames_m1 = 16'(n - 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while ((busy || tx_i < tx_total || (!wr && rx_i < n)) && t < 6000) begin
      lim = tx_total;
      if (mode == 2 && t < 300) lim = 4;
      tx_push = 1'b0;
      rx_pop = 1'b0;
      start = 1'b0;
      if (tx_i < lim && !tx_full) begin
        tx_push = 1'b1;
        if (tx_i == 0) tx_wdata = insw;
        else if (tx_i == 1) tx_wdata = adw;
        else tx_wdata = {24'hA55AC3, byte_of(tx_i - 2, seed)};
        tx_i++;
      end
      if (!rx_empty && !(mode == 1 && t < 300)) begin
        rx_pop = 1'b1;
        if (rx_rdata != byte_of(rx_i, seed)) bad_rd++;
        rx_i++;
      end
      if (mode == 3 && t == 10) begin
        // R9: a start while busy with different settings must change nothing
        start = 1'b1;
        lane_fmt = 2'(3 - fmt);
        addr_code = a32 ? 4'd6 : 4'd8;
        wait_cycles = 5'd2;
        write_mode = !wr;
        frames_m1 = 16'd0;
      end
      if ((mode == 1 || mode == 2) && t == 299) begin
        stall_exp = (mode == 1) ? d0 + RXD * per : d0 + 2 * per;
        check(rise_n == stall_exp && busy && !spi_sclk, (mode == 1) ? "R6 clock held on full receive queue" :
              "R7 clock held on missing word", rise_n, stall_exp);
      end
      @(negedge clk);
      t++;
    end
    tx_push = 1'b0;
    rx_pop = 1'b0;
    start = 1'b0;
    check(t < 6000, "R8 frame completes", t, 6000);
    check(spi_cs_n && !busy && rise_n == total, "R8 clock count and deselect", rise_n, total);
    for (int k = 0; k < total && k < 1024; k++) begin
      int grp;
      if (k < 8) begin
        grp = 1; eo = 4'b0001; ei = {3'b000, insw[7 - k]};
      end else if (k < 8 + ac) begin
        grp = 2; eo = m;
        ei = 4'((adw >> ((a32 ? 32 : 24) - lanes * (k - 8 + 1))) & 32'(m));
      end else if (k < d0) begin
        grp = 3; eo = 4'h0; ei = 4'h0;
      end else begin
        int j, b, p;
        grp = 4;
        j = k - d0; b = j / per; p = j % per;
        if (wr) begin
          eo = m;
          ei = 4'((int'(byte_of(b, seed)) >> (8 - lanes * (p + 1))) & int'(m));
        end else begin
          eo = 4'h0; ei = 4'h0;
        end
      end
      if (cap_oe[k] != eo || cap_io[k] != ei) bad[grp]++;
    end
    check(bad[1] == 0, "R1 instruction clocks", bad[1], 0);
    check(bad[2] == 0, "R2 address clocks", bad[2], 0);
    check(bad[3] == 0, "R3 dummy clocks", bad[3], 0);
    if (wr) check(bad[4] == 0, "R4 write data clocks", bad[4], 0);
    else begin
      check(bad[4] == 0, "R5 read lanes released", bad[4], 0);
      check(bad_rd == 0 && rx_i == n, "R5 read bytes", bad_rd * 1000 + rx_i, n);
    end
    if (mode == 3) check(bad[1] + bad[2] + bad[3] + bad[4] == 0, "R9 start while busy ignored",
                         bad[1] + bad[2] + bad[3] + bad[4], 0);
  endtask

  task automatic refused_start(input logic [1:0] fmt);
    @(negedge clk);
    lane_fmt = fmt;
    write_mode = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    check(!busy && spi_cs_n && !spi_sclk, "R9 refused lane format", {busy, spi_cs_n}, 2'b01);
  endtask

  initial begin
    int seed;
    seed = 1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && spi_cs_n && !spi_sclk && spi_io_oe == 4'h0 && rx_empty, "R10 reset state",
          {busy, spi_cs_n, spi_sclk, spi_io_oe, rx_empty}, 9'b010000001);
    refused_start(2'd0);
    refused_start(2'd3);
    for (int f = 1; f <= 2; f++)
      for (int a = 0; a < 2; a++)
        for (int d = 0; d < 2; d++)
          for (int wi = 0; wi < 2; wi++)
            for (int ni = 0; ni < 2; ni++) begin
              run_frame(f, a[0], wi * 5, d[0], 1 + ni * 2, seed, (wi == 1 && ni == 1) ? 3 : 0);
              seed++;
            end
    run_frame(2, 1'b1, 8, 1'b0, 7, seed, 1); seed++;
    run_frame(1, 1'b0, 0, 1'b1, 5, seed, 2); seed++;
    run_frame(2, 1'b0, 31, 1'b1, 2, seed, 0); seed++;
    run_frame(1, 1'b1, 31, 1'b0, 12, seed, 0); seed++;
    repeat (5) @(negedge clk);
    check(!busy && spi_cs_n && rx_empty, "R8 idle after frames", {busy, spi_cs_n, rx_empty}, 3'b011);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule